// File: doc/BRIEF.md
# Ramped Stereo Gain Stage with Soft and Hard Muting

This block scales a stream of 16-bit two's-complement stereo samples by a gain held in a 9-bit counter, where a count of 256 means unity and each count is one 256th of full scale. The counter never jumps on a level change. It creeps one count toward its setpoint on every fourth sample-rate strobe. If the setpoint moves while a glide is under way, the glide turns toward the newest value at once. Left and right words share the one counter.

Two muting paths sit on top of the gain. A soft mute drives the setpoint to zero, so the output fades along the same glide. Clearing the soft mute snaps the counter back to the live setpoint. A hard mute zeroes the output outright. It can be requested by a control bit, by a pin, or by a buffered-playback mode whose buffer has run dry. The hard mute is sampled only on a left word, so a stereo pair is never split.

Top module: `atten_ramp`

## Requirements
- R1: With `att_en` low the setpoint is 256, and once the counter is there the output equals the input exactly.
- R2: The output word is bits [23:8] of the signed product of the input word and the counter value (an arithmetic shift right by 8, truncating toward minus infinity). With `att_en` high the setpoint is `att_level`.
- R3: The counter moves by exactly one toward its setpoint on every fourth `fs_tick` and holds otherwise. The strobe counter runs freely from reset.
- R4: A setpoint change during a glide redirects the glide toward the new value from the next step on.
- R5: While `soft_mute` is high the setpoint is 0, so a fade from 256 reaches 0 within 1024 strobes.
- R6: One clock after `soft_mute` falls, the counter equals the live setpoint (`att_level` if `att_en` is high, else 256).
- R7: A hard mute from `force_mute` or `mute_pin` makes the output zero. The request is sampled on each left word (`in_left` high) and held for the whole pair.
- R8: The output stays muted until `force_mute`, `mute_pin` and `soft_mute` are all low.
- R9: `buf_mode` high together with `buf_empty` high acts as a hard-mute request.
- R10: After reset the counter is 256, the strobe counter is 0, and both `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_tick | input | 1 | One pulse per sample period |
| in_valid | input | 1 | Input word present this cycle |
| in_left | input | 1 | High when the input word is the left channel |
| in_data | input | 16 | Input sample, two's complement |
| att_en | input | 1 | Use `att_level` as setpoint; low means unity |
| att_level | input | 8 | Gain setpoint in 256ths |
| soft_mute | input | 1 | Fade to zero along the ramp |
| force_mute | input | 1 | Hard mute control bit |
| mute_pin | input | 1 | Hard mute pin |
| buf_mode | input | 1 | Buffered playback mode active |
| buf_empty | input | 1 | Playback buffer holds no data |
| out_valid | output | 1 | Output word present, one cycle after the input |
| out_data | output | 16 | Scaled sample |

## Verification
Two events can land on the same left-word edge: a gain step from the strobe divider and a change in the hard-mute latch. The bench always raises `fs_tick` together with the left word. The left word is therefore scaled by the pre-step counter and the right word by the stepped one, while a hard-mute request raised or dropped between the two words of a pair must leave the right word untouched. A reference model in the bench tracks the counter, the divider phase and the mute latch, and predicts every word of both channels.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/atr_ramp.sv
module atr_ramp #(
  parameter int GW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          att_en,
  input  logic [GW-1:0] att_level,
  input  logic          soft_mute,
  output logic [GW:0]   gain
);
  import atr_pkg::*;

  localparam int GCW  = GW + 1;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [GCW-1:0] FULL = GCW'(1 << GW);
  localparam logic [PW-1:0]  PLAST = PW'(DIV - 1);

  logic [PW-1:0]  pre_q, pre_d;
  logic [GCW-1:0] gain_q, gain_d;
  logic           soft_q;
  logic [GCW-1:0] live_tgt, tgt;
  logic           step_en, soft_rel;
  ramp_dir_e      dir;

  // setpoint without soft mute, and the one the ramp chases
  assign live_tgt = att_en ? {1'b0, att_level} : FULL;
  assign tgt      = soft_mute ? '0 : live_tgt;
  assign step_en  = fs_tick && (pre_q == PLAST);
  assign soft_rel = soft_q && !soft_mute;

  always_comb begin
    if (gain_q < tgt)      dir = RAMP_UP;
    else if (gain_q > tgt) dir = RAMP_DOWN;
    else                   dir = RAMP_HOLD;
  end

  always_comb begin
    pre_d = pre_q;
    if (fs_tick) pre_d = (pre_q == PLAST) ? '0 : pre_q + 1'b1;
  end

  always_comb begin
    gain_d = gain_q;
    if (soft_rel) begin
      gain_d = live_tgt;
    end else if (step_en) begin
      case (dir)
        RAMP_UP:   gain_d = gain_q + 1'b1;
        RAMP_DOWN: gain_d = gain_q - 1'b1;
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      gain_q <= FULL;
      soft_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      gain_q <= gain_d;
      soft_q <= soft_mute;
    end
  end

  assign gain = gain_q;

  // R3: counter moves by at most one count per clock outside a soft release
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rel |=> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1 ||
                   gain_q == $past(gain_q) - 1'b1));
  // R3: no movement without a divided strobe
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !soft_rel) |=> $stable(gain_q));
  // R1: counter never passes unity
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= FULL);
  // R5: soft mute walks down on each step
  a_r5_soft_down: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_mute && soft_q && step_en && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1);
  // R6: release lands on the live setpoint
  a_r6_release_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rel && $stable(att_en) && $stable(att_level)) |=> gain_q == live_tgt);
endmodule

// File: rtl/atr_mute_gate.sv
module atr_mute_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_left,
  input  logic force_mute,
  input  logic mute_pin,
  input  logic buf_mode,
  input  logic buf_empty,
  output logic mute_now
);
  logic req, frame_start;
  logic mute_q, mute_d;

  assign req         = force_mute || mute_pin || (buf_mode && buf_empty);
  assign frame_start = in_valid && in_left;

  always_comb begin
    mute_d = mute_q;
    if (frame_start) mute_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= mute_d;
  end

  // the left word itself already follows the fresh request
  assign mute_now = frame_start ? req : mute_q;

  // R7: latch only changes on a left word
  a_r7_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mute_q));
  // R9: dry buffer in buffered mode mutes the pair
  a_r9_dry_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && buf_mode && buf_empty) |=> mute_q);
endmodule

// File: rtl/atr_scale.sv
module atr_scale #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [GW:0]   gain,
  input  logic          mute_now,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int PW = DW + GW + 2;
  localparam logic [GW:0] FULL = (GW+1)'(1 << GW);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(1 << (DW-1));

  logic signed [PW-1:0] prod, shf;
  logic [DW-1:0] data_d, data_q;
  logic          vld_q;

  assign prod = PW'($signed(in_data)) * $signed({1'b0, gain});
  assign shf  = prod >>> GW;

  always_comb begin
    data_d = data_q;
    if (in_valid) data_d = mute_now ? '0 : shf[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= in_valid;
    end
  end

  assign out_data  = data_q;
  assign out_valid = vld_q;

  // R2: scaled value always fits the output word
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (shf <= MAXV && shf >= MINV));
  // R1: unity gain passes the word unchanged
  a_r1_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mute_now && gain == FULL) |=> out_data == $past(in_data));
  // R7: muted word leaves as zero
  a_r7_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_now) |=> out_data == '0);
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp #(
  parameter int DW  = 16,
  parameter int GW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          in_valid,
  input  logic          in_left,
  input  logic [DW-1:0] in_data,
  input  logic          att_en,
  input  logic [GW-1:0] att_level,
  input  logic          soft_mute,
  input  logic          force_mute,
  input  logic          mute_pin,
  input  logic          buf_mode,
  input  logic          buf_empty,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [GW:0] gain;
  logic        mute_now;

  atr_ramp #(.GW(GW), .DIV(DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .att_en(att_en),
    .att_level(att_level), .soft_mute(soft_mute), .gain(gain)
  );

  atr_mute_gate u_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .force_mute(force_mute), .mute_pin(mute_pin), .buf_mode(buf_mode),
    .buf_empty(buf_empty), .mute_now(mute_now)
  );

  atr_scale #(.DW(DW), .GW(GW)) u_scale (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .gain(gain), .mute_now(mute_now), .out_valid(out_valid), .out_data(out_data)
  );

  // R10: nothing leaves without a word going in
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/tb_atten_ramp.sv
module tb_atten_ramp;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        en;
    logic [7:0]  lvl;
    logic [15:0] din;
    logic [15:0] exp;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b0, 8'd64,  16'h4000, 16'h4000},
    '{1'b1, 8'd64,  16'h4000, 16'h1000},
    '{1'b1, 8'd128, 16'h8000, 16'hC000},
    '{1'b1, 8'd255, 16'h7FFF, 16'h7F7F},
    '{1'b1, 8'd3,   16'hFFFF, 16'hFFFF},
    '{1'b1, 8'd0,   16'h1234, 16'h0000}
  };

  logic clk, rst_n, fs_tick, in_valid, in_left;
  logic [15:0] in_data, out_data;
  logic att_en, soft_mute, force_mute, mute_pin, buf_mode, buf_empty, out_valid;
  logic [7:0] att_level;

  int n_chk, n_bad;
  logic [8:0] g;
  int pre;
  bit fl;
  logic [15:0] last_l, last_r;

  atten_ramp dut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .in_valid(in_valid),
    .in_left(in_left), .in_data(in_data), .att_en(att_en), .att_level(att_level),
    .soft_mute(soft_mute), .force_mute(force_mute), .mute_pin(mute_pin),
    .buf_mode(buf_mode), .buf_empty(buf_empty), .out_valid(out_valid),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [8:0] tgt();
    if (soft_mute) return 9'd0;
    return att_en ? {1'b0, att_level} : 9'd256;
  endfunction

  function automatic logic [15:0] scl(input logic [15:0] d, input logic [8:0] gg);
    int p;
    p = int'($signed(d)) * int'(gg);
    p = p >>> 8;
    return p[15:0];
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mid: 0 nothing, 1 raise force_mute, 2 drop force_mute between the words
  task automatic send_pair(input logic [15:0] l, input logic [15:0] r,
                           input int mid, input string req);
    logic [15:0] el, er;
    logic [8:0] t;
    @(negedge clk);
    fs_tick = 1'b1; in_valid = 1'b1; in_left = 1'b1; in_data = l;
    fl = force_mute || mute_pin || (buf_mode && buf_empty);
    el = fl ? 16'h0 : scl(l, g);
    t = tgt();
    if (pre == 3) begin
      if (g < t) g = g + 1'b1;
      else if (g > t) g = g - 1'b1;
    end
    pre = (pre + 1) % 4;
    @(negedge clk);
    last_l = out_data;
    chk({15'b0, out_valid}, 16'h1, req);
    chk(out_data, el, req);
    if (mid == 1) force_mute = 1'b1;
    if (mid == 2) force_mute = 1'b0;
    fs_tick = 1'b0; in_left = 1'b0; in_data = r;
    er = fl ? 16'h0 : scl(r, g);
    @(negedge clk);
    last_r = out_data;
    chk(out_data, er, req);
    in_valid = 1'b0;
  endtask

  task automatic soft_off();
    @(negedge clk);
    soft_mute = 1'b0;
    @(negedge clk);
    g = tgt();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; g = 9'd256; pre = 0; fl = 1'b0;
    rst_n = 1'b0; fs_tick = 1'b0; in_valid = 1'b0; in_left = 1'b0; in_data = '0;
    att_en = 1'b0; att_level = 8'd64; soft_mute = 1'b0; force_mute = 1'b0;
    mute_pin = 1'b0; buf_mode = 1'b0; buf_empty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk({15'b0, out_valid}, 16'h0, "R10 out_valid");
    chk(out_data, 16'h0, "R10 out_data");
    send_pair(16'h1357, 16'hA5A5, 0, "R10 unity after reset");

    // table walk: settle to each setpoint, then compare with row result
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      att_en = ROWS[i].en; att_level = ROWS[i].lvl;
      while (g != tgt()) send_pair(16'h4000, 16'h4000, 0, "R3 glide");
      send_pair(ROWS[i].din, ROWS[i].din, 0, "R2 settled");
      chk(last_r, ROWS[i].exp, i == 0 ? "R1 table" : "R2 table");
    end

    // R4: redirect mid-glide
    @(negedge clk); att_level = 8'd200;
    repeat (40) send_pair(16'h4000, 16'hC000, 0, "R4 up");
    @(negedge clk); att_level = 8'd5;
    while (g != 9'd5) send_pair(16'h4000, 16'hC000, 0, "R4 down");
    send_pair(16'h4000, 16'h4000, 0, "R4");
    chk(last_l, 16'd320, "R4 final");

    // R5: full fade from unity
    @(negedge clk); att_en = 1'b0;
    while (g != 9'd256) send_pair(16'h4000, 16'h4000, 0, "R1 glide");
    @(negedge clk); soft_mute = 1'b1;
    send_pair(16'h4000, 16'h4000, 0, "R5 start");
    chk(last_l, 16'h4000, "R5 first word full");
    repeat (1023) send_pair(16'h4000, 16'h4000, 0, "R5 fade");
    chk(last_r, 16'h0, "R5 faded by 1024");

    // R6: release jumps to live setpoint
    @(negedge clk); att_en = 1'b1; att_level = 8'd64;
    send_pair(16'h4000, 16'h4000, 0, "R5 held");
    soft_off();
    send_pair(16'h4000, 16'h4000, 0, "R6");
    chk(last_l, 16'h1000, "R6 jump");

    // R7: control bit, engaged and dropped between the words of a pair
    send_pair(16'h4000, 16'h4000, 1, "R7 set mid-pair");
    chk(last_r, 16'h1000, "R7 right untouched");
    send_pair(16'h4000, 16'h4000, 2, "R7 muted pair");
    chk(last_r, 16'h0, "R7 right stays muted");
    send_pair(16'h4000, 16'h4000, 0, "R7 released");
    chk(last_l, 16'h1000, "R7 release at left");

    // R7 pin, R8 all sources must clear
    @(negedge clk); mute_pin = 1'b1;
    send_pair(16'h2000, 16'h2000, 0, "R7 pin");
    chk(last_l, 16'h0, "R7 pin mutes");
    @(negedge clk); force_mute = 1'b1; mute_pin = 1'b0;
    send_pair(16'h2000, 16'h2000, 0, "R8 bit still set");
    chk(last_l, 16'h0, "R8 still muted");
    @(negedge clk); force_mute = 1'b0; soft_mute = 1'b1;
    send_pair(16'h4000, 16'h4000, 0, "R8 soft still set");
    soft_off();
    send_pair(16'h4000, 16'h4000, 0, "R8 all clear");
    chk(last_l, 16'h1000, "R8 all clear");

    // R9: buffered mode with dry buffer
    @(negedge clk); buf_mode = 1'b1;
    send_pair(16'h4000, 16'h4000, 0, "R9 buffer has data");
    chk(last_l, 16'h1000, "R9 not empty");
    @(negedge clk); buf_empty = 1'b1;
    send_pair(16'h4000, 16'h4000, 0, "R9 dry");
    chk(last_l, 16'h0, "R9 dry mutes");
    @(negedge clk); buf_mode = 1'b0;
    send_pair(16'h4000, 16'h4000, 0, "R9 mode off");
    chk(last_l, 16'h1000, "R9 mode off plays");

    finish_run();
  end
endmodule